// File: doc/BRIEF.md
# Operand-Order Branch Condition Unit

This block decides whether a two-byte conditional branch is taken and computes where it goes. The first instruction byte holds a three-bit major opcode, one condition bit and two 2-bit register indices. The second byte holds a second condition bit and a 7-bit signed offset. The two condition bits select one of four base comparisons.

There is no bit for negating a condition. The negated form is chosen by the order of the register indices. When the first index is numerically smaller than the second, the base comparison is applied. When it is larger, the complement is applied. When the two indices are equal, the encoding belongs to other instructions, such as the unconditional jump, so the branch is reported as not valid.

The surrounding pipeline supplies the two instruction bytes, the values read from the two indexed registers, and the address of the next instruction. All three results come from one register stage.

Top module: `bcu_branch_unit`

## Requirements
- R1: `br_valid_o` is 1 one cycle after the inputs are sampled exactly when `op_hi_i[7:5]` is `110` and the index field `op_hi_i[3:2]` differs from the index field `op_hi_i[1:0]`. The opcode check alone gives 0 for any other opcode.
- R2: When the two index fields are equal, `br_valid_o` and `br_taken_o` are 0. This includes the jump byte `1100_0000`.
- R3: The condition code is `{op_hi_i[4], op_lo_i[7]}`: `00` is equality, `01` is bit-test, `10` is signed less-than and `11` is unsigned less-than. When `op_hi_i[3:2] < op_hi_i[1:0]`, the comparison is evaluated as `reg_a_i OP reg_b_i`.
- R4: When `op_hi_i[3:2] > op_hi_i[1:0]`, the taken flag is the complement of the R3 result. This gives not-equal, test-clear, signed `a >= b` and unsigned `a >= b`.
- R5: Bit-test holds when `reg_a_i & reg_b_i` is nonzero. Signed and unsigned less-than give opposite answers when exactly one operand has bit 15 set (for example `0x8000` against `0x0001`).
- R6: `br_target_o` equals `pc_next_i` plus `op_lo_i[6:0]` sign-extended to 16 bits, modulo 2^16. It is updated every cycle whatever the opcode.
- R7: `br_taken_o` is 0 whenever `br_valid_o` is 0.
- R8: While `rst_n` is low, all outputs are 0.
- R9: Every output reflects the inputs present at the preceding rising clock edge, with a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_hi_i | input | 8 | First instruction byte: major opcode, condition bit, index fields |
| op_lo_i | input | 8 | Second instruction byte: condition bit and 7-bit offset |
| reg_a_i | input | 16 | Value of the register named by `op_hi_i[3:2]` |
| reg_b_i | input | 16 | Value of the register named by `op_hi_i[1:0]` |
| pc_next_i | input | 16 | Address of the instruction after the branch |
| br_valid_o | output | 1 | Inputs were a conditional branch encoding |
| br_taken_o | output | 1 | Branch condition held |
| br_target_o | output | 16 | Next address plus sign-extended offset |

## Verification
All three results (valid, taken and target) are due exactly one rising edge after the inputs that produce them. The bench drives each new input set on a falling edge and pushes its expected results into a one-deep queue. At the next falling edge, by which time that single register stage has loaded, it pops the queue and compares. This means each comparison is against the vector applied one cycle earlier, never the one being driven. The reset values are checked on a falling edge while reset is still held low.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  localparam int IDX_W    = 2;
  localparam int OFF_W    = 7;
  localparam int COND_W   = 2;
  localparam int NUM_COND = 1 << COND_W;
  localparam int BYTE_W   = 8;

  localparam logic [2:0] BR_MAJOR = 3'b110;

  typedef enum logic [COND_W-1:0] {
    COND_EQ   = 2'b00,
    COND_TEST = 2'b01,
    COND_SLT  = 2'b10,
    COND_ULT  = 2'b11
  } cond_e;

  typedef struct packed {
    logic [2:0]       major;
    cond_e            cond;
    logic [IDX_W-1:0] idx_a;
    logic [IDX_W-1:0] idx_b;
    logic [OFF_W-1:0] offset;
  } br_fields_t;

endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
  import bcu_pkg::*;
(
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] op_lo,
  output br_fields_t        fields,
  output logic              is_branch,
  output logic              idx_same,
  output logic              swapped
);

  always_comb begin
    fields.major  = op_hi[BYTE_W-1 -: 3];
    fields.cond   = cond_e'({op_hi[4], op_lo[BYTE_W-1]});
    fields.idx_a  = op_hi[2*IDX_W-1:IDX_W];
    fields.idx_b  = op_hi[IDX_W-1:0];
    fields.offset = op_lo[OFF_W-1:0];
  end

  // Index order picks base comparison (a<b) or its complement (a>b)
  assign is_branch = (fields.major == BR_MAJOR);
  assign idx_same  = (fields.idx_a == fields.idx_b);
  assign swapped   = (fields.idx_a > fields.idx_b);

endmodule

// File: rtl/bcu_compare.sv
module bcu_compare
  import bcu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cond_e             cond,
  input  logic              swapped,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              base_hit,
  output logic              cond_hit
);

  function automatic logic base_eval(input cond_e c,
                                     input logic [DATA_W-1:0] l,
                                     input logic [DATA_W-1:0] r);
    logic res;
    case (c)
      COND_EQ:   res = ~|(l ^ r);
      COND_TEST: res = |(l & r);
      COND_SLT:  res = ($signed(l) < $signed(r));
      default:   res = (l < r);
    endcase
    return res;
  endfunction

  logic [NUM_COND-1:0] lane_hit;

  // One comparator lane per base condition; code selects a lane
  for (genvar g = 0; g < NUM_COND; g++) begin : g_lane
    localparam logic [COND_W-1:0] LANE_CODE = g;
    assign lane_hit[g] = base_eval(cond_e'(LANE_CODE), lhs, rhs);
  end

  assign base_hit = lane_hit[cond];
  assign cond_hit = base_hit ^ swapped;

endmodule

// File: rtl/bcu_target.sv
module bcu_target
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_next,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] o);
    return {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  assign target = pc_next + sext_off(offset);

endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        op_hi_i,
  input  logic [7:0]        op_lo_i,
  input  logic [DATA_W-1:0] reg_a_i,
  input  logic [DATA_W-1:0] reg_b_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  output logic              br_valid_o,
  output logic              br_taken_o,
  output logic [ADDR_W-1:0] br_target_o
);

  br_fields_t        dec_fields;
  logic              is_branch_w;
  logic              idx_same_w;
  logic              swap_w;
  logic              valid_w;
  logic              base_hit_w;
  logic              cond_hit_w;
  logic [ADDR_W-1:0] target_w;

  bcu_decode u_decode (
    .op_hi     (op_hi_i),
    .op_lo     (op_lo_i),
    .fields    (dec_fields),
    .is_branch (is_branch_w),
    .idx_same  (idx_same_w),
    .swapped   (swap_w)
  );

  bcu_compare #(.DATA_W(DATA_W)) u_compare (
    .cond     (dec_fields.cond),
    .swapped  (swap_w),
    .lhs      (reg_a_i),
    .rhs      (reg_b_i),
    .base_hit (base_hit_w),
    .cond_hit (cond_hit_w)
  );

  bcu_target #(.ADDR_W(ADDR_W)) u_target (
    .pc_next (pc_next_i),
    .offset  (dec_fields.offset),
    .target  (target_w)
  );

  assign valid_w = is_branch_w & ~idx_same_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid_o  <= 1'b0;
      br_taken_o  <= 1'b0;
      br_target_o <= '0;
    end else begin
      br_valid_o  <= valid_w;
      br_taken_o  <= valid_w & cond_hit_w;
      br_target_o <= target_w;
    end
  end

endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        op_hi_i,
  input logic [7:0]        op_lo_i,
  input logic [DATA_W-1:0] reg_a_i,
  input logic [DATA_W-1:0] reg_b_i,
  input logic [ADDR_W-1:0] pc_next_i,
  input logic              br_valid_o,
  input logic              br_taken_o,
  input logic [ADDR_W-1:0] br_target_o,
  input logic              idx_same_w,
  input logic              swap_w,
  input logic              valid_w
);

  localparam int EXT_W = ADDR_W - 7;

  logic [1:0] code_w;
  assign code_w = {op_hi_i[4], op_lo_i[7]};

  p_opcode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hi_i[7:5] != 3'b110) |=> !br_valid_o);

  p_same_idx_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_same_w |=> (!br_valid_o && !br_taken_o));

  p_eq_order_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_w && code_w == 2'b00) |=>
      (br_taken_o == ($past(swap_w) ^ ($past(reg_a_i) == $past(reg_b_i)))));

  p_test_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_w && code_w == 2'b01) |=>
      (br_taken_o == ($past(swap_w) ^ (|($past(reg_a_i) & $past(reg_b_i))))));

  p_target_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (br_target_o == $past(pc_next_i) +
              {{EXT_W{$past(op_lo_i[6])}}, $past(op_lo_i[6:0])}));

  p_taken_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_o |-> br_valid_o);

endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_hi_i     (op_hi_i),
  .op_lo_i     (op_lo_i),
  .reg_a_i     (reg_a_i),
  .reg_b_i     (reg_b_i),
  .pc_next_i   (pc_next_i),
  .br_valid_o  (br_valid_o),
  .br_taken_o  (br_taken_o),
  .br_target_o (br_target_o),
  .idx_same_w  (idx_same_w),
  .swap_w      (swap_w),
  .valid_w     (valid_w)
);

// File: tb/bcu_branch_unit_tb.sv
module bcu_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  op_hi = '0;
  logic [7:0]  op_lo = '0;
  logic [15:0] ra = '0;
  logic [15:0] rb = '0;
  logic [15:0] pc = '0;
  logic        v_o, t_o;
  logic [15:0] tgt_o;

  int n_vec  = 0;
  int n_fail = 0;
  int cycles = 0;

  typedef struct {
    logic        v;
    logic        t;
    logic [15:0] tgt;
  } exp_t;

  exp_t exp_q[$];

  always #10 clk = ~clk;

  bcu_branch_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_hi_i     (op_hi),
    .op_lo_i     (op_lo),
    .reg_a_i     (ra),
    .reg_b_i     (rb),
    .pc_next_i   (pc),
    .br_valid_o  (v_o),
    .br_taken_o  (t_o),
    .br_target_o (tgt_o)
  );

  // Behavioural model of the requirements, integer arithmetic only
  function automatic exp_t model(input logic [7:0] hi, input logic [7:0] lo,
                                 input logic [15:0] a, input logic [15:0] b,
                                 input logic [15:0] p);
    exp_t e;
    int ia = int'(hi[3:2]);
    int ib = int'(hi[1:0]);
    int code = (hi[4] ? 2 : 0) + (lo[7] ? 1 : 0);
    int ua = int'(a);
    int ub = int'(b);
    int sa = (ua >= 32768) ? ua - 65536 : ua;
    int sb = (ub >= 32768) ? ub - 65536 : ub;
    int off = int'(lo[6:0]);
    bit hit;
    if (off >= 64) off = off - 128;
    case (code)
      0: hit = (ua == ub);
      1: hit = ((a & b) != 16'h0);
      2: hit = (sa < sb);
      default: hit = (ua < ub);
    endcase
    if (ib < ia) hit = !hit;
    e.v   = (hi[7:5] == 3'b110) && (ia != ib);
    e.t   = e.v && hit;
    e.tgt = 16'((int'(p) + off + 65536) % 65536);
    return e;
  endfunction

  task automatic compare_one(input exp_t e);
    n_vec++;
    if (v_o !== e.v) begin
      n_fail++;
      $display("FAIL R1 R2 R9 valid: actual %b expected %b", v_o, e.v);
    end
    if (t_o !== e.t) begin
      n_fail++;
      $display("FAIL R3 R4 R5 R7 taken: actual %b expected %b", t_o, e.t);
    end
    if (tgt_o !== e.tgt) begin
      n_fail++;
      $display("FAIL R6 target: actual %h expected %h", tgt_o, e.tgt);
    end
  endtask

  // Drive on falling edge, check previous vector one cycle later (R9)
  task automatic apply(input logic [7:0] hi, input logic [7:0] lo,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] p);
    @(negedge clk);
    if (exp_q.size() > 0) compare_one(exp_q.pop_front());
    op_hi = hi; op_lo = lo; ra = a; rb = b; pc = p;
    exp_q.push_back(model(hi, lo, a, b, p));
  endtask

  task automatic br(input int code, input int ia, input int ib,
                    input logic [15:0] a, input logic [15:0] b,
                    input logic [6:0] off, input logic [15:0] p);
    logic [1:0] c = 2'(code);
    apply({3'b110, c[1], 2'(ia), 2'(ib)}, {c[0], off}, a, b, p);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    op_hi = 8'hD6; op_lo = 8'hFF; ra = 16'h1234; rb = 16'h1234; pc = 16'h4000;
    repeat (3) @(negedge clk);
    // R8: outputs clear during reset
    n_vec++;
    if (v_o !== 1'b0 || t_o !== 1'b0 || tgt_o !== 16'h0) begin
      n_fail++;
      $display("FAIL R8 reset: actual %b %b %h expected 0 0 0000", v_o, t_o, tgt_o);
    end
    rst_n = 1'b1;

    // R3: base conditions with a-index below b-index
    br(0, 0, 1, 16'h00AA, 16'h00AA, 7'd4, 16'h0100);
    br(0, 1, 3, 16'h00AA, 16'h00AB, 7'd4, 16'h0100);
    br(1, 0, 2, 16'h0F00, 16'h0100, 7'd1, 16'h0200);
    br(1, 2, 3, 16'h0F00, 16'h00F0, 7'd1, 16'h0200);
    br(2, 0, 3, 16'hFFFF, 16'h0001, 7'd9, 16'h0300);
    br(3, 0, 3, 16'hFFFF, 16'h0001, 7'd9, 16'h0300);
    // R4: swapped order gives complements
    br(0, 1, 0, 16'h00AA, 16'h00AA, 7'd4, 16'h0100);
    br(0, 3, 1, 16'h00AA, 16'h00AB, 7'd4, 16'h0100);
    br(1, 2, 0, 16'h0F00, 16'h0100, 7'd1, 16'h0200);
    br(1, 3, 2, 16'h0F00, 16'h00F0, 7'd1, 16'h0200);
    br(2, 3, 0, 16'h0005, 16'h0005, 7'd2, 16'h0300);
    br(3, 3, 0, 16'h0004, 16'h0005, 7'd2, 16'h0300);
    // R5: signedness boundary 0x8000 vs 0x0001
    br(2, 0, 1, 16'h8000, 16'h0001, 7'd0, 16'h0010);
    br(3, 0, 1, 16'h8000, 16'h0001, 7'd0, 16'h0010);
    br(2, 1, 0, 16'h8000, 16'h0001, 7'd0, 16'h0010);
    br(3, 1, 0, 16'h8000, 16'h0001, 7'd0, 16'h0010);
    // R2: equal indices, including the jump byte
    apply(8'hC0, 8'h05, 16'h0000, 16'h0000, 16'h0020);
    br(0, 2, 2, 16'h0007, 16'h0007, 7'd3, 16'h0020);
    br(1, 3, 3, 16'hFFFF, 16'hFFFF, 7'd3, 16'h0020);
    // R1 R7: other opcodes never valid, never taken
    apply(8'h86, 8'h80, 16'h0001, 16'h0001, 16'h0040);
    apply(8'hE1, 8'h00, 16'h0002, 16'h0002, 16'h0040);
    apply(8'hF6, 8'h80, 16'h0003, 16'h0003, 16'h0040);
    // R6: offset extremes and address wrap
    br(0, 0, 1, 16'h1, 16'h1, 7'h40, 16'h0010);
    br(0, 0, 1, 16'h1, 16'h1, 7'h3F, 16'hFFF0);
    br(0, 0, 1, 16'h1, 16'h1, 7'h7F, 16'h0000);
    // Mixed pseudo-random vectors, biased toward the branch opcode
    for (int i = 0; i < 600; i++) begin
      logic [7:0] h = 8'($urandom);
      if (i % 4 != 0) h[7:5] = 3'b110;
      apply(h, 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    end
    @(negedge clk);
    if (exp_q.size() > 0) compare_one(exp_q.pop_front());
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule